// File: doc/BRIEF.md
# Configurable Branch Target Buffer

This block predicts branches for an instruction fetch stage. It holds a small, fully associative table of recently taken branches. Each entry keeps a word-aligned branch address, that branch's target and a 2-bit saturating confidence counter. Each cycle the fetch side presents an address and the direction of the branch found there. In the same cycle the block returns a hit flag, a predicted target and a taken/not-taken decision. When the table has no matching entry, a static rule picks the decision from the branch direction.

The execute stage reports each resolved branch with its address, its real target, its direction and whether it was taken. A report that matches an entry refreshes that entry's target and moves its counter. A taken report that matches no entry may create a new entry, subject to a direction-based allocation policy. A 32-bit control register holds four things: the enable, the allocation policy, the static prediction policy, and a self-clearing command that invalidates every entry at once.

The block has no state machine. It is one register stage of table state in front of combinational lookup and policy logic.

Top module: `brpred_unit`

## Requirements
- R1: After reset the control register reads 0x00000000, no fetch address hits, and every miss is predicted taken (static policy 00).
- R2: Writing the control register with bit 9 set clears every entry's valid bit at the next clock edge, whether the enable is 0 or 1. Bit 9 always reads back as 0. If a resolved branch arrives in the same cycle as this write, the invalidate wins and the branch creates no entry.
- R3: Control register layout, counting bit 0 as the least significant bit: bit 0 is enable, bits 2:1 are the static policy, bits 5:4 are the allocation policy, and bit 9 is invalidate. All other bits ignore writes and read as 0, so writing 0xFFFFFFFF reads back 0x00000037.
- R4: With the enable at 1, a taken resolved branch that misses, and is allowed by the policy, creates an entry. From the next cycle a fetch of that address hits, predicts taken and returns the reported target. A new entry's counter starts at 2'b10.
- R5: With the enable at 0, nothing hits, no entry is created, and resolved branches change no counter. Existing entries keep their valid bits and hit again, unchanged, once the enable returns to 1.
- R6: Allocation policy (bits 5:4): 00 allows both directions, 01 blocks backward branches, 10 blocks forward branches, 11 blocks both.
- R7: Static policy (bits 2:1), applied on every miss: 00 predicts taken for both directions, 01 predicts taken only for forward branches, 10 predicts taken only for backward branches, 11 predicts not taken. Direction input 1 means backward (the displacement's sign bit is set), and 0 means forward.
- R8: A hit's outcome ignores both policies. A resolved branch that hits refreshes its entry's target and counter even when allocation is blocked for its direction.
- R9: A hit predicts taken exactly when the counter's upper bit is 1. A taken report adds 1 to the counter, saturating at 2'b11. A not-taken report subtracts 1, saturating at 2'b00.
- R10: A new entry goes into the lowest-numbered invalid entry. When every entry is valid, it replaces a victim chosen round-robin, starting from entry 0 after reset.
- R11: A not-taken resolved branch that misses never creates an entry.
- R12: On a miss the predicted target output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr_en | input | 1 | Write strobe for the control register |
| csr_wr_data | input | 32 | Control register write value |
| csr_rd_data | output | 32 | Control register read value |
| fetch_addr | input | AW | Address being fetched |
| fetch_bwd | input | 1 | Direction of the fetched branch, 1 = backward |
| pred_hit | output | 1 | Table hit for fetch_addr |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | AW | Predicted target on a hit, zero on a miss |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_addr | input | AW | Resolved branch address |
| res_target | input | AW | Resolved branch target |
| res_bwd | input | 1 | Resolved branch direction, 1 = backward |
| res_taken | input | 1 | Resolved branch was taken |

## Verification
The bench builds the block with its default parameters: eight entries and 32-bit addresses. Because the table is this shallow, a handful of resolved branches fills it. The bench can therefore reach both the lowest-free-slot choice and two successive round-robin replacements within a few dozen cycles. With 32-bit addresses, the bench spaces its branch addresses widely, so no two of them can share a tag.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

    localparam int CSR_W        = 32;
    localparam int BIT_EN       = 0;
    localparam int BIT_SPRED_LO = 1;
    localparam int BIT_ALLOC_LO = 4;
    localparam int BIT_FLUSH    = 9;

    localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

    typedef struct packed {
        logic       en;
        logic [1:0] alloc;
        logic [1:0] spred;
    } brpred_cfg_t;

endpackage

// File: rtl/brpred_csr.sv
module brpred_csr
    import brpred_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output brpred_cfg_t      cfg,
    output logic             flush,
    output logic [CSR_W-1:0] rd_data
);

    brpred_cfg_t cfg_q;
    logic        unused_rsvd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.en    <= wr_data[BIT_EN];
            cfg_q.spred <= wr_data[BIT_SPRED_LO +: 2];
            cfg_q.alloc <= wr_data[BIT_ALLOC_LO +: 2];
        end
    end

    // Invalidate is a one-cycle command, never stored
    assign flush = wr_en && wr_data[BIT_FLUSH];
    assign cfg   = cfg_q;

    always_comb begin
        rd_data                       = '0;
        rd_data[BIT_EN]               = cfg_q.en;
        rd_data[BIT_SPRED_LO +: 2]    = cfg_q.spred;
        rd_data[BIT_ALLOC_LO +: 2]    = cfg_q.alloc;
    end

    assign unused_rsvd = ^wr_data;

endmodule

// File: rtl/brpred_policy.sv
module brpred_policy
    import brpred_pkg::*;
(
    input  brpred_cfg_t cfg,
    input  logic        fetch_bwd,
    input  logic        res_bwd,
    output logic        miss_taken,
    output logic        alloc_ok
);

    // Static decision on a miss
    always_comb begin
        unique case (cfg.spred)
            2'b00:   miss_taken = 1'b1;
            2'b01:   miss_taken = !fetch_bwd;
            2'b10:   miss_taken = fetch_bwd;
            default: miss_taken = 1'b0;
        endcase
    end

    // alloc[0] blocks backward, alloc[1] blocks forward
    always_comb begin
        if (res_bwd) alloc_ok = !cfg.alloc[0];
        else         alloc_ok = !cfg.alloc[1];
    end

endmodule

// File: rtl/brpred_store.sv
module brpred_store
    import brpred_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int AW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic          lk_taken,
    output logic [AW-1:0] lk_target,
    input  logic          up_valid,
    input  logic [AW-1:0] up_addr,
    input  logic [AW-1:0] up_target,
    input  logic          up_taken,
    input  logic          alloc_ok
);

    localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TAGW = AW - 2;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ENTRIES - 1);

    logic [ENTRIES-1:0] valid_q;
    logic [TAGW-1:0]    tag_q [ENTRIES];
    logic [AW-1:0]      tgt_q [ENTRIES];
    logic [1:0]         ctr_q [ENTRIES];
    logic [IDXW-1:0]    rr_q;

    logic [ENTRIES-1:0] lk_match, up_match;
    logic               up_hit, free_any, alloc_fire;
    logic [IDXW-1:0]    up_idx, free_idx, alloc_idx;
    logic               unused_low;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_addr[AW-1:2]);
        assign up_match[g] = valid_q[g] && (tag_q[g] == up_addr[AW-1:2]);
    end

    assign unused_low = ^{lk_addr[1:0], up_addr[1:0]};

    // Fetch-side lookup, combinational
    always_comb begin
        lk_hit    = en && (|lk_match);
        lk_taken  = 1'b0;
        lk_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (en && lk_match[i]) begin
                lk_taken  = ctr_q[i][1];
                lk_target = tgt_q[i];
            end
        end
    end

    // Update-side selection
    always_comb begin
        up_hit   = en && (|up_match);
        up_idx   = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (up_match[i]) up_idx = IDXW'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_any = 1'b1;
                free_idx = IDXW'(i);
            end
        end
        alloc_fire = en && up_valid && !up_hit && up_taken && alloc_ok;
        alloc_idx  = free_any ? free_idx : rr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i] <= '0;
                tgt_q[i] <= '0;
                ctr_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (en && up_valid && up_hit) begin
            tgt_q[up_idx] <= up_target;
            if (up_taken) begin
                if (ctr_q[up_idx] != 2'b11) ctr_q[up_idx] <= ctr_q[up_idx] + 2'd1;
            end else begin
                if (ctr_q[up_idx] != 2'b00) ctr_q[up_idx] <= ctr_q[up_idx] - 2'd1;
            end
        end else if (alloc_fire) begin
            valid_q[alloc_idx] <= 1'b1;
            tag_q[alloc_idx]   <= up_addr[AW-1:2];
            tgt_q[alloc_idx]   <= up_target;
            ctr_q[alloc_idx]   <= CTR_WEAK_TAKEN;
            if (!free_any) begin
                rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
            end
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R2

    AST_OFF_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !flush) |=> $stable(valid_q)); // R5

    AST_TAGS_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R10

    AST_NEW_ENTRY_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !flush) |=> (ctr_q[$past(alloc_idx)] == CTR_WEAK_TAKEN)); // R4

endmodule

// File: rtl/brpred_unit.sv
module brpred_unit
    import brpred_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int AW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_wr_en,
    input  logic [31:0]   csr_wr_data,
    output logic [31:0]   csr_rd_data,
    input  logic [AW-1:0] fetch_addr,
    input  logic          fetch_bwd,
    output logic          pred_hit,
    output logic          pred_taken,
    output logic [AW-1:0] pred_target,
    input  logic          res_valid,
    input  logic [AW-1:0] res_addr,
    input  logic [AW-1:0] res_target,
    input  logic          res_bwd,
    input  logic          res_taken
);

    brpred_cfg_t   cfg;
    logic          flush;
    logic          miss_taken, alloc_ok;
    logic          lk_hit, lk_taken;
    logic [AW-1:0] lk_target;

    brpred_csr i_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_wr_en),
        .wr_data (csr_wr_data),
        .cfg     (cfg),
        .flush   (flush),
        .rd_data (csr_rd_data)
    );

    brpred_policy i_policy (
        .cfg        (cfg),
        .fetch_bwd  (fetch_bwd),
        .res_bwd    (res_bwd),
        .miss_taken (miss_taken),
        .alloc_ok   (alloc_ok)
    );

    brpred_store #(.ENTRIES(ENTRIES), .AW(AW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.en),
        .flush     (flush),
        .lk_addr   (fetch_addr),
        .lk_hit    (lk_hit),
        .lk_taken  (lk_taken),
        .lk_target (lk_target),
        .up_valid  (res_valid),
        .up_addr   (res_addr),
        .up_target (res_target),
        .up_taken  (res_taken),
        .alloc_ok  (alloc_ok)
    );

    assign pred_hit    = lk_hit;
    assign pred_taken  = lk_hit ? lk_taken : miss_taken;
    assign pred_target = lk_hit ? lk_target : '0;

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !pred_hit); // R5

    AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !csr_rd_data[BIT_FLUSH]); // R2

endmodule

// File: tb/test_brpred_unit.sv
`timescale 1ns/1ps
module test_brpred_unit;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr_en = 1'b0;
    logic [31:0]   csr_wr_data = '0;
    logic [31:0]   csr_rd_data;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_bwd = 1'b0;
    logic          pred_hit, pred_taken;
    logic [AW-1:0] pred_target;
    logic          res_valid = 1'b0;
    logic [AW-1:0] res_addr = '0, res_target = '0;
    logic          res_bwd = 1'b0, res_taken = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    brpred_unit #(.ENTRIES(8), .AW(AW)) i_brpred_unit (.*);

    always #4 clk = ~clk;

    function automatic logic [31:0] cfgw(logic en, logic [1:0] al, logic [1:0] sp, logic fl);
        return {22'd0, fl, 3'd0, al, 1'b0, sp, en};
    endfunction

    function automatic logic stat_exp(logic [1:0] sp, logic bwd);
        case (sp)
            2'b00:   return 1'b1;
            2'b01:   return !bwd;
            2'b10:   return bwd;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_csr(logic [31:0] d);
        csr_wr_en = 1'b1; csr_wr_data = d;
        @(negedge clk);
        csr_wr_en = 1'b0; csr_wr_data = '0;
    endtask

    task automatic resolve(logic [AW-1:0] a, logic [AW-1:0] t, logic bwd, logic tk);
        res_valid = 1'b1; res_addr = a; res_target = t; res_bwd = bwd; res_taken = tk;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic look(string req, logic [AW-1:0] a, logic bwd,
                        logic eh, logic et, logic [AW-1:0] etg);
        fetch_addr = a; fetch_bwd = bwd;
        #1;
        chk(req, $sformatf("hit @%h", a), 32'(pred_hit), 32'(eh));
        chk(req, $sformatf("taken @%h", a), 32'(pred_taken), 32'(et));
        chk(req, $sformatf("target @%h", a), pred_target, eh ? etg : '0);
    endtask

    task automatic t_reset();
        chk("R1", "csr after reset", csr_rd_data, 32'h0);
        look("R1", 32'h0000_0040, 1'b1, 1'b0, 1'b1, '0);
        look("R12", 32'h0000_0080, 1'b0, 1'b0, 1'b1, '0);
    endtask

    task automatic t_fields();
        wr_csr(32'hFFFF_FFFF);
        chk("R3", "all-ones readback", csr_rd_data, 32'h0000_0037);
        wr_csr(cfgw(1'b0, 2'b10, 2'b01, 1'b0));
        chk("R3", "field readback", csr_rd_data, 32'h0000_0022);
        wr_csr(32'h0);
    endtask

    task automatic t_static();
        for (int sp = 0; sp < 4; sp++) begin
            wr_csr(cfgw(1'b0, 2'b00, 2'(sp), 1'b0));
            for (int b = 0; b < 2; b++)
                look("R7", 32'h0000_0100, 1'(b), 1'b0, stat_exp(2'(sp), 1'(b)), '0);
        end
    endtask

    task automatic t_alloc_basic();
        wr_csr(cfgw(1'b1, 2'b00, 2'b11, 1'b1));
        resolve(32'h0000_0100, 32'h0000_0200, 1'b0, 1'b1);
        look("R4", 32'h0000_0100, 1'b0, 1'b1, 1'b1, 32'h0000_0200);
        resolve(32'h0000_0300, 32'h0000_0400, 1'b0, 1'b0);
        look("R11", 32'h0000_0300, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_counter();
        // entry at 0x100 starts at 10
        resolve(32'h100, 32'h200, 1'b0, 1'b0);   // 01
        look("R9", 32'h100, 1'b0, 1'b1, 1'b0, 32'h200);
        resolve(32'h100, 32'h200, 1'b0, 1'b0);   // 00
        resolve(32'h100, 32'h200, 1'b0, 1'b0);   // stays 00
        resolve(32'h100, 32'h200, 1'b0, 1'b1);   // 01
        look("R9", 32'h100, 1'b0, 1'b1, 1'b0, 32'h200);
        resolve(32'h100, 32'h200, 1'b0, 1'b1);   // 10
        look("R9", 32'h100, 1'b0, 1'b1, 1'b1, 32'h200);
        resolve(32'h100, 32'h200, 1'b0, 1'b1);   // 11
        resolve(32'h100, 32'h200, 1'b0, 1'b1);   // stays 11
        resolve(32'h100, 32'h200, 1'b0, 1'b0);   // 10
        look("R9", 32'h100, 1'b0, 1'b1, 1'b1, 32'h200);
    endtask

    task automatic t_blocked_hit();
        wr_csr(cfgw(1'b1, 2'b11, 2'b11, 1'b0));
        resolve(32'h100, 32'h280, 1'b0, 1'b1);
        look("R8", 32'h100, 1'b0, 1'b1, 1'b1, 32'h280);
        wr_csr(cfgw(1'b1, 2'b11, 2'b00, 1'b0));
        resolve(32'h100, 32'h2C0, 1'b0, 1'b0);
        resolve(32'h100, 32'h2C0, 1'b0, 1'b0);
        look("R8", 32'h100, 1'b0, 1'b1, 1'b0, 32'h2C0);
        resolve(32'h500, 32'h600, 1'b0, 1'b1);
        look("R6", 32'h500, 1'b0, 1'b0, 1'b1, '0);
    endtask

    task automatic t_alloc_policy();
        for (int code = 0; code < 4; code++) begin
            for (int b = 0; b < 2; b++) begin
                logic ok;
                ok = b ? !code[0] : !code[1];
                wr_csr(cfgw(1'b1, 2'(code), 2'b11, 1'b1));
                resolve(32'h0000_0700, 32'h0000_0800, 1'(b), 1'b1);
                look("R6", 32'h0000_0700, 1'(b), ok, ok, 32'h0000_0800);
            end
        end
    endtask

    task automatic t_disable();
        wr_csr(cfgw(1'b1, 2'b00, 2'b11, 1'b1));
        resolve(32'h900, 32'hA00, 1'b1, 1'b1);
        wr_csr(cfgw(1'b0, 2'b00, 2'b11, 1'b0));
        look("R5", 32'h900, 1'b1, 1'b0, 1'b0, '0);
        resolve(32'hB00, 32'hC00, 1'b0, 1'b1);
        resolve(32'h900, 32'hA40, 1'b1, 1'b0);
        resolve(32'h900, 32'hA40, 1'b1, 1'b0);
        wr_csr(cfgw(1'b1, 2'b00, 2'b11, 1'b0));
        look("R5", 32'h900, 1'b1, 1'b1, 1'b1, 32'hA00);
        look("R5", 32'hB00, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_flush();
        wr_csr(cfgw(1'b0, 2'b00, 2'b11, 1'b1));
        chk("R2", "flush bit reads 0", 32'(csr_rd_data[9]), 32'h0);
        wr_csr(cfgw(1'b1, 2'b00, 2'b11, 1'b0));
        look("R2", 32'h900, 1'b1, 1'b0, 1'b0, '0);
        csr_wr_en = 1'b1; csr_wr_data = cfgw(1'b1, 2'b00, 2'b11, 1'b1);
        res_valid = 1'b1; res_addr = 32'hD00; res_target = 32'hE00;
        res_bwd = 1'b0; res_taken = 1'b1;
        @(negedge clk);
        csr_wr_en = 1'b0; res_valid = 1'b0;
        look("R2", 32'hD00, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_replace();
        wr_csr(cfgw(1'b1, 2'b00, 2'b11, 1'b1));
        for (int i = 0; i < 8; i++)
            resolve(32'h1000 + 32'(i) * 32'h10, 32'h8000 + 32'(i), 1'b0, 1'b1);
        for (int i = 0; i < 8; i++)
            look("R10", 32'h1000 + 32'(i) * 32'h10, 1'b0, 1'b1, 1'b1, 32'h8000 + 32'(i));
        resolve(32'h1080, 32'h8008, 1'b0, 1'b1);
        look("R10", 32'h1000, 1'b0, 1'b0, 1'b0, '0);
        look("R10", 32'h1010, 1'b0, 1'b1, 1'b1, 32'h8001);
        look("R10", 32'h1080, 1'b0, 1'b1, 1'b1, 32'h8008);
        resolve(32'h1090, 32'h8009, 1'b0, 1'b1);
        look("R10", 32'h1010, 1'b0, 1'b0, 1'b0, '0);
        look("R10", 32'h1020, 1'b0, 1'b1, 1'b1, 32'h8002);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_static();
        t_alloc_basic();
        t_counter();
        t_blocked_hit();
        t_alloc_policy();
        t_disable();
        t_flush();
        t_replace();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule